// File: doc/BRIEF.md
# Atomic Instruction-Group Commit Controller

This block retires one statically placed instruction group as a single indivisible unit. When a group is launched, the controller records how many instructions the group holds and how many register results it will produce. While the group executes, it counts instruction completions and resolves which exit the group leaves by. Register results and stores are parked in two small holding buffers, and none of them becomes visible outside the block until the whole group has finished.

Branch results arrive in program order. A branch only counts if every branch before it fell through, so the first taken branch fixes the exit. If no branch is taken, the group leaves through its final instruction, and the exit index is then the number of branches seen. After every instruction has completed and every declared register result has arrived, the controller empties the register buffer and then the store buffer, one entry per cycle. It then pulses a done strobe. A flush abandons the group at any point and discards everything that was buffered.

Top module: `grp_commit_ctrl`

## Requirements
- R1: `state_o` is encoded as 0 for idle, 1 for executing, 2 for committing and 3 for done. A `start_i` seen while idle latches `start_ninsn_i` and `start_nout_i`, clears the counters, the buffers, the exit index and the error flag, and moves the block to executing on the next cycle.
- R2: The block leaves the executing state only on the cycle after the number of accepted completions equals the declared instruction count and the number of register-write events equals the declared output count. A group declared with zero instructions and zero outputs goes straight to committing.
- R3: A register write received while executing is held back. It never appears on the `rf_*` port before the committing state. In the committing state, held writes leave in arrival order, one per cycle, with `rf_we_o` high.
- R4: Held stores leave on the `mem_*` port in arrival order, one per cycle. They start only after the register buffer is empty.
- R5: `exit_o` counts the not-taken branches that come before the first taken branch. Any branch after the first taken one has no effect. If no branch is taken, `exit_o` equals the number of branches received. The count saturates at its maximum value.
- R6: The cycle after the committing state finds both buffers empty, the block is in the done state with `commit_done_o` high for exactly one cycle. It returns to idle on the following cycle.
- R7: A completion event received while idle has no effect: the state stays idle and `err_o` does not change.
- R8: A completion that arrives while the completion count already equals the declared total sets `err_o`. The flag stays set until the next start or flush.
- R9: Each buffer holds 8 entries. A write or store that arrives while its buffer is full is dropped and sets `err_o`.
- R10: `flush_i` returns the block to idle on the next cycle from any state. It discards both buffers and clears `err_o` and `exit_o`.
- R11: After reset the block is idle, with no write strobes, no done pulse, `err_o` low and `exit_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Abandon the current group |
| start_i | input | 1 | Launch a group (accepted only while idle) |
| start_ninsn_i | input | CNT_W | Number of instructions in the group |
| start_nout_i | input | CNT_W | Number of register results of the group |
| done_evt_i | input | 1 | One instruction completed |
| wr_evt_i | input | 1 | Register result produced |
| wr_idx_i | input | IDX_W | Destination register index |
| wr_data_i | input | DATA_W | Result value |
| st_evt_i | input | 1 | Store produced |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| br_evt_i | input | 1 | Branch resolved (program order) |
| br_taken_i | input | 1 | Resolved branch was taken |
| state_o | output | 2 | Controller state |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_idx_o | output | IDX_W | Register-file write index |
| rf_data_o | output | DATA_W | Register-file write value |
| mem_we_o | output | 1 | Store strobe |
| mem_addr_o | output | ADDR_W | Store address |
| mem_data_o | output | DATA_W | Store data |
| exit_o | output | EXIT_W | Selected exit index |
| commit_done_o | output | 1 | One-cycle pulse when the group has been committed |
| err_o | output | 1 | Sticky error flag |

## Verification
The groups used have different branch patterns: one where a taken branch sits in the middle and later branches follow it, one where all branches fall through, and one with no branches and an empty body. Together these separate first-taken resolution from last-branch or any-taken behaviour. A group whose completions arrive before its register result shows that commit waits on both counts. Groups that fill both buffers past capacity, or that report one completion too many, expose drop and error handling. A flush issued with writes still pending shows whether anything leaks onto the register or store ports.

// File: rtl/grp_commit_pkg.sv
// Shared types for the group commit controller.
package grp_commit_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EXEC   = 2'd1,
        S_COMMIT = 2'd2,
        S_DONE   = 2'd3
    } grp_state_e;
endpackage

// File: rtl/grp_out_buf.sv
// Holding buffer for deferred results. Circular FIFO of DEPTH entries.
// Assumes push and pop are never requested in the same cycle by the owner;
// a push while full is dropped and flagged on ovf_o in that cycle.
module grp_out_buf #(
    parameter int W     = 37,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign ovf_o   = push_i && full_o;
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign dout_o  = mem[rd_q];

    // Next pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din_i;
    end

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !clr_i) |=> full_o);
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i && !clr_i) |=> empty_o);
endmodule

// File: rtl/grp_done_tracker.sv
// Counts instruction completions and register-output events against the
// totals declared at group start. all_done_o is combinational from the
// registered counts; excess_o flags a completion beyond the total.
module grp_done_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] ninsn_i,
    input  logic [CNT_W-1:0] nout_i,
    input  logic             en_i,
    input  logic             done_evt_i,
    input  logic             wr_evt_i,
    output logic             all_done_o,
    output logic             excess_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] ninsn_q, nout_q, dcnt_q, wcnt_q;

    assign all_done_o = (dcnt_q == ninsn_q) && (wcnt_q == nout_q);
    assign excess_o   = en_i && done_evt_i && (dcnt_q == ninsn_q);

    // Totals latch and event counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            ninsn_q <= '0;
            nout_q  <= '0;
            dcnt_q  <= '0;
            wcnt_q  <= '0;
        end else if (load_i) begin
            ninsn_q <= ninsn_i;
            nout_q  <= nout_i;
            dcnt_q  <= '0;
            wcnt_q  <= '0;
        end else if (en_i) begin
            if (done_evt_i && dcnt_q != ninsn_q) dcnt_q <= dcnt_q + 1'b1;
            if (wr_evt_i && wcnt_q != CNT_MAX)   wcnt_q <= wcnt_q + 1'b1;
        end
    end

    p_no_overcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && done_evt_i && dcnt_q == ninsn_q && !clr_i && !load_i) |=> $stable(dcnt_q));
endmodule

// File: rtl/grp_exit_resolver.sv
// Resolves the group exit from in-order branch results: each branch only
// counts if all earlier ones fell through. The index saturates.
module grp_exit_resolver #(
    parameter int EXIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              br_evt_i,
    input  logic              br_taken_i,
    output logic [EXIT_W-1:0] exit_o
);
    localparam logic [EXIT_W-1:0] EXIT_MAX = '1;

    logic              found_q;
    logic [EXIT_W-1:0] exit_q;

    assign exit_o = exit_q;

    // Chain: a taken branch freezes the index, a fall-through advances it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            found_q <= 1'b0;
            exit_q  <= '0;
        end else if (en_i && br_evt_i && !found_q) begin
            if (br_taken_i)            found_q <= 1'b1;
            else if (exit_q != EXIT_MAX) exit_q <= exit_q + 1'b1;
        end
    end

    p_exit_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && !clr_i) |=> $stable(exit_q));
endmodule

// File: rtl/grp_commit_ctrl.sv
// Atomic group commit controller. Tracks one group from start to commit,
// holds register results and stores until every instruction is done,
// then drains registers first, then stores, one entry per cycle.
// Assumes branch events arrive in program order and that events are
// only meaningful while executing.
module grp_commit_ctrl
    import grp_commit_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 8,
    parameter int WB_DEPTH = 8,
    parameter int ST_DEPTH = 8,
    parameter int EXIT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  start_ninsn_i,
    input  logic [CNT_W-1:0]  start_nout_i,
    input  logic              done_evt_i,
    input  logic              wr_evt_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              st_evt_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic              br_evt_i,
    input  logic              br_taken_i,
    output logic [1:0]        state_o,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [DATA_W-1:0] rf_data_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic [EXIT_W-1:0] exit_o,
    output logic              commit_done_o,
    output logic              err_o
);
    localparam int RW = IDX_W + DATA_W;
    localparam int SW = ADDR_W + DATA_W;

    grp_state_e      st_q;
    logic            err_q;
    logic            launch, clr_grp, in_exec, in_commit;
    logic            all_done, excess;
    logic            rq_empty, rq_full, rq_ovf, rq_pop;
    logic            sq_empty, sq_full, sq_ovf, sq_pop;
    logic [RW-1:0]   rq_head;
    logic [SW-1:0]   sq_head;

    assign launch    = (st_q == S_IDLE) && start_i && !flush_i;
    assign clr_grp   = flush_i || launch;
    assign in_exec   = (st_q == S_EXEC);
    assign in_commit = (st_q == S_COMMIT);
    assign rq_pop    = in_commit && !rq_empty;
    assign sq_pop    = in_commit && rq_empty && !sq_empty;

    grp_done_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (flush_i),
        .load_i     (launch),
        .ninsn_i    (start_ninsn_i),
        .nout_i     (start_nout_i),
        .en_i       (in_exec),
        .done_evt_i (done_evt_i),
        .wr_evt_i   (wr_evt_i),
        .all_done_o (all_done),
        .excess_o   (excess)
    );

    grp_exit_resolver #(.EXIT_W(EXIT_W)) u_exit (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_grp),
        .en_i       (in_exec),
        .br_evt_i   (br_evt_i),
        .br_taken_i (br_taken_i),
        .exit_o     (exit_o)
    );

    grp_out_buf #(.W(RW), .DEPTH(WB_DEPTH)) u_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_grp),
        .push_i  (in_exec && wr_evt_i),
        .din_i   ({wr_idx_i, wr_data_i}),
        .pop_i   (rq_pop),
        .dout_o  (rq_head),
        .empty_o (rq_empty),
        .full_o  (rq_full),
        .ovf_o   (rq_ovf)
    );

    grp_out_buf #(.W(SW), .DEPTH(ST_DEPTH)) u_sbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_grp),
        .push_i  (in_exec && st_evt_i),
        .din_i   ({st_addr_i, st_data_i}),
        .pop_i   (sq_pop),
        .dout_o  (sq_head),
        .empty_o (sq_empty),
        .full_o  (sq_full),
        .ovf_o   (sq_ovf)
    );

    // Group lifecycle state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            st_q <= S_IDLE;
        end else begin
            case (st_q)
                S_IDLE:   if (start_i) st_q <= S_EXEC;
                S_EXEC:   if (all_done) st_q <= S_COMMIT;
                S_COMMIT: if (rq_empty && sq_empty) st_q <= S_DONE;
                default:  st_q <= S_IDLE;
            endcase
        end
    end

    // Sticky error flag, cleared by a new group or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_grp)                    err_q <= 1'b0;
        else if (in_exec && (excess || rq_ovf || sq_ovf)) err_q <= 1'b1;
    end

    assign state_o       = st_q;
    assign err_o         = err_q;
    assign commit_done_o = (st_q == S_DONE);
    assign rf_we_o       = rq_pop;
    assign {rf_idx_o, rf_data_o}   = rq_head;
    assign mem_we_o      = sq_pop;
    assign {mem_addr_o, mem_data_o} = sq_head;

    p_commit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && !flush_i && !all_done) |=> st_q == S_EXEC);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done_o |=> !commit_done_o && st_q == S_IDLE);
    p_idle_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !start_i && !flush_i) |=> (st_q == S_IDLE && $stable(err_o)));
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q == S_IDLE && !err_o && exit_o == '0));
    p_store_after_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !rf_we_o && rq_empty);
    p_no_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC) |-> !rf_we_o && !mem_we_o);
endmodule

// File: tb/grp_commit_ctrl_bench.sv
// Lockstep bench: behavioural reference model compared on every clock.
module grp_commit_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 0, start = 0, done_evt = 0, wr_evt = 0, st_evt = 0;
    logic        br_evt = 0, br_taken = 0;
    logic [7:0]  ninsn = 0, nout = 0;
    logic [4:0]  widx = 0;
    logic [31:0] wdata = 0, saddr = 0, sdata = 0;

    logic [1:0]  state_o;
    logic        rf_we_o, mem_we_o, commit_done_o, err_o;
    logic [4:0]  rf_idx_o;
    logic [31:0] rf_data_o, mem_addr_o, mem_data_o;
    logic [2:0]  exit_o;

    int checks = 0, fails = 0, cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    grp_commit_ctrl u_grp_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .start_i(start),
        .start_ninsn_i(ninsn), .start_nout_i(nout), .done_evt_i(done_evt),
        .wr_evt_i(wr_evt), .wr_idx_i(widx), .wr_data_i(wdata),
        .st_evt_i(st_evt), .st_addr_i(saddr), .st_data_i(sdata),
        .br_evt_i(br_evt), .br_taken_i(br_taken), .state_o(state_o),
        .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .exit_o(exit_o), .commit_done_o(commit_done_o), .err_o(err_o)
    );

    // Reference model state
    int          m_st = 0, m_n = 0, m_o = 0, m_d = 0, m_w = 0, m_exit = 0;
    bit          m_found = 0, m_err = 0, go;
    logic [36:0] rq[$];
    logic [63:0] sq[$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Model update on each clock edge.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            summary();
        end
        if (!rst_n || flush) begin
            m_st = 0; rq.delete(); sq.delete(); m_err = 0; m_exit = 0; m_found = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_n = ninsn; m_o = nout; m_d = 0; m_w = 0;
                    rq.delete(); sq.delete(); m_err = 0; m_exit = 0; m_found = 0; m_st = 1;
                end
                1: begin
                    go = (m_d == m_n) && (m_w == m_o);
                    if (done_evt) begin
                        if (m_d == m_n) m_err = 1; else m_d++;
                    end
                    if (wr_evt) begin
                        if (m_w < 255) m_w++;
                        if (rq.size() >= 8) m_err = 1; else rq.push_back({widx, wdata});
                    end
                    if (st_evt) begin
                        if (sq.size() >= 8) m_err = 1; else sq.push_back({saddr, sdata});
                    end
                    if (br_evt && !m_found) begin
                        if (br_taken) m_found = 1; else if (m_exit < 7) m_exit++;
                    end
                    if (go) m_st = 2;
                end
                2: begin
                    if (rq.size() > 0) void'(rq.pop_front());
                    else if (sq.size() > 0) void'(sq.pop_front());
                    else m_st = 3;
                end
                default: m_st = 0;
            endcase
        end
    end

    // Lockstep comparison away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk("R1 R2 state", {62'd0, state_o}, 64'(m_st));
            chk("R3 rf_we", {63'd0, rf_we_o}, 64'(m_st == 2 && rq.size() > 0));
            if (m_st == 2 && rq.size() > 0) chk("R3 rf order", {27'd0, rf_idx_o, rf_data_o}, 64'(rq[0]));
            chk("R4 mem_we", {63'd0, mem_we_o}, 64'(m_st == 2 && rq.size() == 0 && sq.size() > 0));
            if (m_st == 2 && rq.size() == 0 && sq.size() > 0) chk("R4 store order", {mem_addr_o, mem_data_o}, sq[0]);
            chk("R6 done pulse", {63'd0, commit_done_o}, 64'(m_st == 3));
            chk("R5 exit", {61'd0, exit_o}, 64'(m_exit));
            chk("R8 R9 err", {63'd0, err_o}, 64'(m_err));
        end
    end

    task automatic tick();
        @(negedge clk);
        flush = 0; start = 0; done_evt = 0; wr_evt = 0; st_evt = 0; br_evt = 0; br_taken = 0;
    endtask

    task automatic launch(input int n, input int o);
        start = 1; ninsn = 8'(n); nout = 8'(o); tick();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 64; i++) begin
            if (m_st == 0) break;
            tick();
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        // R11 reset state
        chk("R11 state", {62'd0, state_o}, 0);
        chk("R11 err", {63'd0, err_o}, 0);
        chk("R11 strobes", {61'd0, rf_we_o, mem_we_o, commit_done_o}, 0);
        chk("R11 exit", {61'd0, exit_o}, 0);

        // R7 completions while idle
        done_evt = 1; tick(); done_evt = 1; tick();
        chk("R7 idle state", {62'd0, state_o}, 0);
        chk("R7 idle err", {63'd0, err_o}, 0);

        // Mid-group taken branch, later branch ignored (R5), writes and store
        launch(4, 2);
        wr_evt = 1; widx = 5'd3; wdata = 32'hA1; done_evt = 1; tick();
        br_evt = 1; br_taken = 0; tick();
        st_evt = 1; saddr = 32'h100; sdata = 32'h55; done_evt = 1; tick();
        br_evt = 1; br_taken = 1; wr_evt = 1; widx = 5'd7; wdata = 32'hB2; done_evt = 1; tick();
        br_evt = 1; br_taken = 0; done_evt = 1; tick();
        wait_idle();
        chk("R5 first taken exit", {61'd0, exit_o}, 1);

        // R2: all completions but output missing keeps executing
        launch(2, 1);
        done_evt = 1; tick(); done_evt = 1; tick(); tick(); tick();
        chk("R2 waits for output", {62'd0, state_o}, 1);
        wr_evt = 1; widx = 5'd9; wdata = 32'hC3; tick();
        wait_idle();

        // No taken branch: final-instruction exit (R5)
        launch(1, 0);
        br_evt = 1; tick(); br_evt = 1; tick(); br_evt = 1; tick(); done_evt = 1; tick();
        wait_idle();
        chk("R5 fall-through exit", {61'd0, exit_o}, 3);

        // Empty group commits at once (R2)
        launch(0, 0);
        wait_idle();
        chk("R2 empty group idle", {62'd0, state_o}, 0);

        // R9 overflow of both buffers
        launch(1, 9);
        for (int i = 0; i < 9; i++) begin
            wr_evt = 1; widx = 5'(i); wdata = 32'(i * 17 + 1);
            st_evt = 1; saddr = 32'(i * 4); sdata = 32'(i + 200); tick();
        end
        done_evt = 1; tick();
        chk("R9 overflow err", {63'd0, err_o}, 1);
        wait_idle();

        // R8 excess completion; cleared by next start
        launch(2, 0);
        done_evt = 1; tick(); done_evt = 1; tick(); done_evt = 1; tick();
        chk("R8 excess err", {63'd0, err_o}, 1);
        wait_idle();
        launch(1, 0);
        chk("R8 err cleared by start", {63'd0, err_o}, 0);
        done_evt = 1; tick();
        wait_idle();

        // R10 flush with pending writes
        launch(3, 2);
        wr_evt = 1; widx = 5'd1; wdata = 32'hD4; tick();
        wr_evt = 1; widx = 5'd2; wdata = 32'hE5; st_evt = 1; saddr = 32'h40; tick();
        br_evt = 1; tick();
        done_evt = 1; tick();
        flush = 1; tick();
        chk("R10 flush state", {62'd0, state_o}, 0);
        chk("R10 flush exit", {61'd0, exit_o}, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R10 no leaked write", {62'd0, rf_we_o, mem_we_o}, 0);
        end

        summary();
    end
endmodule